// File: doc/BRIEF.md
# PCI Address Window Translator

This block sits beside a PCI host bridge and turns addresses from one side of the bridge into addresses on the other. Three outbound windows take local-bus addresses into PCI space. Three inbound windows take addresses issued by PCI bus masters into local memory. Software sets up every window through a small 32-bit register port with a one-cycle read latency. Each direction has its own purely combinational lookup. A lookup returns a hit flag, the index of the window that matched and the translated 64-bit address.

Each window is sized by a mask register, and bit 0 of that register enables the window. The window length is the two's complement of the mask once its low bits are cleared. An outbound window's local base and PCI base are each 64 bits, programmed as two 32-bit halves. An inbound window always starts at PCI address zero and carries only a 64-bit local base. The third outbound window keeps its size register for software but has no base registers and never translates.

Top module: `pci_xlate_unit`

## Requirements
- R1: After reset every window register reads zero except the inbound size registers, which reset to 0xFFFFFFFF_00000000 (upper half at 0xF8 reads 0xFFFFFFFF). No window hits after reset.
- R2: A window whose size register has bit 0 clear never hits, whatever the address.
- R3: Outbound length is (~(size & 0xFFFFFFFE) + 1) mod 2^32. If that is zero, the length is 0xFFFFFFFF, so offset 0xFFFFFFFE hits and offset 0xFFFFFFFF misses.
- R4: An outbound window hits when (local address − local base) mod 2^64 is below its length, and the output is PCI base + that offset. On a miss the output address and index are zero. Window w (w = 0, 1) has local low/high at 0x68+0x14w / 0x6C+0x14w, size at 0x70+0x14w, and PCI low/high at 0x74+0x14w / 0x78+0x14w.
- R5: Outbound window 2 has only a size register, at 0x90. It reads back what was written and never produces a hit.
- R6: An inbound window w hits when the PCI address is below (~(size & ~7) + 1) mod 2^64, and the output is local base + PCI address. Size low, local low and local high sit at 0x98+0xCw, 0x9C+0xCw and 0xA0+0xCw.
- R7: When no inbound window hits, the inbound output equals the input address, and the hit flag and index are zero.
- R8: When several enabled windows of one direction hit, the lowest-numbered one is reported.
- R9: A write to one 32-bit half of a 64-bit register leaves the other half unchanged. Inbound size upper halves exist for window 0 (0xF8) and window 2 (0xFC).
- R10: A write to the inbound window 1 size register (0xA4) loads the full 64-bit size with the value zero-extended. Only the low half reads back.
- R11: The status register at 0xE0 reads back the last 32-bit value written to it.
- R12: A read of any offset not listed returns zero, and a write to one changes no register and no lookup result.
- R13: Read data appears on the port in the cycle after the read request and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the request |
| ob_addr_in | input | 64 | Local-bus address to translate outbound |
| ob_hit | output | 1 | An outbound window matched |
| ob_win_idx | output | 2 | Index of the matching outbound window |
| ob_addr_out | output | 64 | Translated PCI address |
| ib_addr_in | input | 64 | PCI bus-master address to translate inbound |
| ib_hit | output | 1 | An inbound window matched |
| ib_win_idx | output | 2 | Index of the matching inbound window |
| ib_addr_out | output | 64 | Translated local address, or the input on a miss |

## Verification
The bench probes the exact window edges. The last offset must hit and the first offset past the window must miss, and an address just below the base must miss through wrap-around. A design that used <= instead of < would claim one extra address, and one with a signed compare would accept addresses below the base. A zero outbound length must widen to 0xFFFFFFFF and not shrink to nothing. The bench overlaps windows to expose a reversed priority order. It writes the window 1 inbound size to catch a design that keeps the old upper half and so produces a tiny window. It also writes halves one at a time and touches unmapped offsets, which catches a design that clobbers neighbouring storage.

// File: rtl/pxw_pkg.sv
package pxw_pkg;

  localparam int REG_AW     = 8;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 64;

  localparam int NUM_OB     = 3;
  localparam int NUM_OB_XL  = 2;
  localparam int NUM_IB     = 3;
  localparam int OB_IDX_W   = (NUM_OB > 1) ? $clog2(NUM_OB) : 1;
  localparam int IB_IDX_W   = (NUM_IB > 1) ? $clog2(NUM_IB) : 1;

  // register offsets that software decodes
  localparam int OFF_OB_BASE   = 'h68;
  localparam int OB_STRIDE     = 'h14;
  localparam int OFF_OB_SZONLY = 'h90;
  localparam int OFF_IB_BASE   = 'h98;
  localparam int IB_STRIDE     = 'h0C;
  localparam int OFF_IB_SZH    = 'hF8;
  localparam int OFF_STATUS    = 'hE0;

  // inbound windows that own an upper size half
  localparam logic [NUM_IB-1:0] IB_SZH_MASK = 3'b101;

  localparam logic [ADDR_W-1:0] IB_SZ_RST = 64'hFFFF_FFFF_0000_0000;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [WORD_W-1:0] word_t;

  // field slot inside an outbound window register group
  typedef enum int {
    OBF_LA_LO = 0,
    OBF_LA_HI = 1,
    OBF_SIZE  = 2,
    OBF_PA_LO = 3,
    OBF_PA_HI = 4
  } ob_field_e;

  // field slot inside an inbound window register group
  typedef enum int {
    IBF_SZ_LO = 0,
    IBF_LA_LO = 1,
    IBF_LA_HI = 2
  } ib_field_e;

endpackage

// File: rtl/pxw_rst_sync.sv
module pxw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/pxw_regfile.sv
module pxw_regfile
  import pxw_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_valid,
  input  logic                    reg_write,
  input  logic [REG_AW-1:0]       reg_addr,
  input  word_t                   reg_wdata,
  output word_t                   reg_rdata,
  output addr_t [NUM_OB_XL-1:0]   ob_la_q,
  output addr_t [NUM_OB_XL-1:0]   ob_pa_q,
  output word_t [NUM_OB-1:0]      ob_sz_q,
  output addr_t [NUM_IB-1:0]      ib_sz_q,
  output addr_t [NUM_IB-1:0]      ib_la_q
);

  function automatic logic [REG_AW-1:0] ob_off(input int w, input ob_field_e f);
    return REG_AW'(OFF_OB_BASE + w * OB_STRIDE + 4 * int'(f));
  endfunction

  function automatic logic [REG_AW-1:0] ib_off(input int w, input ib_field_e f);
    return REG_AW'(OFF_IB_BASE + w * IB_STRIDE + 4 * int'(f));
  endfunction

  addr_t [NUM_OB_XL-1:0] ob_la_d, ob_pa_d;
  word_t [NUM_OB-1:0]    ob_sz_d;
  addr_t [NUM_IB-1:0]    ib_sz_d, ib_la_d;
  word_t                 sts_q, sts_d;
  word_t                 rdata_q;
  word_t                 rd_val;
  logic                  wr_en, rd_en;
  int                    hi_slot;

  assign wr_en = reg_valid &  reg_write;
  assign rd_en = reg_valid & ~reg_write;

  // next-state and read mux
  always_comb begin
    ob_la_d = ob_la_q;
    ob_pa_d = ob_pa_q;
    ob_sz_d = ob_sz_q;
    ib_sz_d = ib_sz_q;
    ib_la_d = ib_la_q;
    sts_d   = sts_q;
    rd_val  = '0;
    hi_slot = 0;

    for (int w = 0; w < NUM_OB_XL; w++) begin
      if (reg_addr == ob_off(w, OBF_LA_LO)) begin
        rd_val = ob_la_q[w][31:0];
        if (wr_en) ob_la_d[w][31:0] = reg_wdata;
      end
      if (reg_addr == ob_off(w, OBF_LA_HI)) begin
        rd_val = ob_la_q[w][63:32];
        if (wr_en) ob_la_d[w][63:32] = reg_wdata;
      end
      if (reg_addr == ob_off(w, OBF_SIZE)) begin
        rd_val = ob_sz_q[w];
        if (wr_en) ob_sz_d[w] = reg_wdata;
      end
      if (reg_addr == ob_off(w, OBF_PA_LO)) begin
        rd_val = ob_pa_q[w][31:0];
        if (wr_en) ob_pa_d[w][31:0] = reg_wdata;
      end
      if (reg_addr == ob_off(w, OBF_PA_HI)) begin
        rd_val = ob_pa_q[w][63:32];
        if (wr_en) ob_pa_d[w][63:32] = reg_wdata;
      end
    end

    // size-only outbound windows
    for (int w = NUM_OB_XL; w < NUM_OB; w++) begin
      if (reg_addr == REG_AW'(OFF_OB_SZONLY + 4 * (w - NUM_OB_XL))) begin
        rd_val = ob_sz_q[w];
        if (wr_en) ob_sz_d[w] = reg_wdata;
      end
    end

    for (int w = 0; w < NUM_IB; w++) begin
      if (reg_addr == ib_off(w, IBF_SZ_LO)) begin
        rd_val = ib_sz_q[w][31:0];
        if (wr_en) begin
          if (IB_SZH_MASK[w]) ib_sz_d[w][31:0] = reg_wdata;
          else                ib_sz_d[w]       = {32'h0, reg_wdata};
        end
      end
      if (reg_addr == ib_off(w, IBF_LA_LO)) begin
        rd_val = ib_la_q[w][31:0];
        if (wr_en) ib_la_d[w][31:0] = reg_wdata;
      end
      if (reg_addr == ib_off(w, IBF_LA_HI)) begin
        rd_val = ib_la_q[w][63:32];
        if (wr_en) ib_la_d[w][63:32] = reg_wdata;
      end
      if (IB_SZH_MASK[w]) begin
        if (reg_addr == REG_AW'(OFF_IB_SZH + 4 * hi_slot)) begin
          rd_val = ib_sz_q[w][63:32];
          if (wr_en) ib_sz_d[w][63:32] = reg_wdata;
        end
        hi_slot = hi_slot + 1;
      end
    end

    if (reg_addr == REG_AW'(OFF_STATUS)) begin
      rd_val = sts_q;
      if (wr_en) sts_d = reg_wdata;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ob_la_q <= '0;
      ob_pa_q <= '0;
      ob_sz_q <= '0;
      ib_sz_q <= {NUM_IB{IB_SZ_RST}};
      ib_la_q <= '0;
      sts_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_en) begin
        ob_la_q <= ob_la_d;
        ob_pa_q <= ob_pa_d;
        ob_sz_q <= ob_sz_d;
        ib_sz_q <= ib_sz_d;
        ib_la_q <= ib_la_d;
        sts_q   <= sts_d;
      end
      if (rd_en) rdata_q <= rd_val;
    end
  end

  assign reg_rdata = rdata_q;

  // R13: read data changes only after a read request
  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(reg_rdata));

endmodule

// File: rtl/pxw_ob_lookup.sv
module pxw_ob_lookup
  import pxw_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int IDX_W   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  addr_t [NUM_WIN-1:0]  win_la,
  input  addr_t [NUM_WIN-1:0]  win_pa,
  input  word_t [NUM_WIN-1:0]  win_sz,
  input  addr_t                addr_in,
  output logic                 hit,
  output logic [IDX_W-1:0]     idx,
  output addr_t                addr_out
);

  logic [NUM_WIN-1:0]  match;
  addr_t [NUM_WIN-1:0] target;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    word_t len_raw, len;
    addr_t offset;
    assign len_raw = ~(win_sz[w] & 32'hFFFF_FFFE) + 32'd1;
    assign len     = (len_raw == '0) ? 32'hFFFF_FFFF : len_raw;
    assign offset  = addr_in - win_la[w];
    assign match[w]  = win_sz[w][0] && (offset < {32'h0, len});
    assign target[w] = win_pa[w] + offset;
  end

  // lowest index wins: scan from the top so lower entries override
  always_comb begin
    hit      = 1'b0;
    idx      = '0;
    addr_out = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit      = 1'b1;
        idx      = IDX_W'(w);
        addr_out = target[w];
      end
    end
  end

  // R2: a reported window is always enabled
  p_ob_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> win_sz[idx][0]);

  // R4: a miss reports index zero
  p_ob_miss_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (idx == '0 && addr_out == '0));

endmodule

// File: rtl/pxw_ib_lookup.sv
module pxw_ib_lookup
  import pxw_pkg::*;
#(
  parameter int NUM_WIN = 3,
  parameter int IDX_W   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  addr_t [NUM_WIN-1:0]  win_sz,
  input  addr_t [NUM_WIN-1:0]  win_la,
  input  addr_t                addr_in,
  output logic                 hit,
  output logic [IDX_W-1:0]     idx,
  output addr_t                addr_out
);

  logic [NUM_WIN-1:0]  match;
  addr_t [NUM_WIN-1:0] target;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    addr_t len;
    assign len       = ~(win_sz[w] & ~64'h7) + 64'd1;
    assign match[w]  = win_sz[w][0] && (addr_in < len);
    assign target[w] = win_la[w] + addr_in;
  end

  always_comb begin
    hit      = 1'b0;
    idx      = '0;
    addr_out = addr_in;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit      = 1'b1;
        idx      = IDX_W'(w);
        addr_out = target[w];
      end
    end
  end

  // R2: a reported window is always enabled
  p_ib_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> win_sz[idx][0]);

  // R7: a miss passes the address through
  p_ib_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (addr_out == addr_in && idx == '0));

endmodule

// File: rtl/pci_xlate_unit.sv
module pci_xlate_unit
  import pxw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_valid,
  input  logic                 reg_write,
  input  logic [7:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [63:0]          ob_addr_in,
  output logic                 ob_hit,
  output logic [1:0]           ob_win_idx,
  output logic [63:0]          ob_addr_out,
  input  logic [63:0]          ib_addr_in,
  output logic                 ib_hit,
  output logic [1:0]           ib_win_idx,
  output logic [63:0]          ib_addr_out
);

  logic                  rst_sn;
  addr_t [NUM_OB_XL-1:0] ob_la, ob_pa;
  word_t [NUM_OB-1:0]    ob_sz;
  addr_t [NUM_IB-1:0]    ib_sz, ib_la;

  pxw_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sn)
  );

  pxw_regfile u_regfile (
    .clk       (clk),
    .rst_n     (rst_sn),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ob_la_q   (ob_la),
    .ob_pa_q   (ob_pa),
    .ob_sz_q   (ob_sz),
    .ib_sz_q   (ib_sz),
    .ib_la_q   (ib_la)
  );

  // only the translating outbound windows get a comparator
  pxw_ob_lookup #(.NUM_WIN(NUM_OB_XL), .IDX_W(OB_IDX_W)) u_ob_lookup (
    .clk      (clk),
    .rst_n    (rst_sn),
    .win_la   (ob_la),
    .win_pa   (ob_pa),
    .win_sz   (ob_sz[NUM_OB_XL-1:0]),
    .addr_in  (ob_addr_in),
    .hit      (ob_hit),
    .idx      (ob_win_idx),
    .addr_out (ob_addr_out)
  );

  pxw_ib_lookup #(.NUM_WIN(NUM_IB), .IDX_W(IB_IDX_W)) u_ib_lookup (
    .clk      (clk),
    .rst_n    (rst_sn),
    .win_sz   (ib_sz),
    .win_la   (ib_la),
    .addr_in  (ib_addr_in),
    .hit      (ib_hit),
    .idx      (ib_win_idx),
    .addr_out (ib_addr_out)
  );

  // R5: the size-only outbound window never reports a hit
  p_ob_sizeonly_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    ob_hit |-> (ob_win_idx < 2'(NUM_OB_XL)));

endmodule

// File: tb/pci_xlate_unit_bench.sv
module pci_xlate_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_valid, reg_write;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [63:0] ob_addr_in, ob_addr_out, ib_addr_in, ib_addr_out;
  logic        ob_hit, ib_hit;
  logic [1:0]  ob_win_idx, ib_win_idx;

  int checks   = 0;
  int failures = 0;
  bit started  = 0;
  bit done     = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pci_xlate_unit u_pci_xlate_unit (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ob_addr_in(ob_addr_in), .ob_hit(ob_hit), .ob_win_idx(ob_win_idx),
    .ob_addr_out(ob_addr_out),
    .ib_addr_in(ib_addr_in), .ib_hit(ib_hit), .ib_win_idx(ib_win_idx),
    .ib_addr_out(ib_addr_out)
  );

  // ---------------- behavioural reference model ----------------
  bit [63:0] m_ob_la [2];
  bit [63:0] m_ob_pa [2];
  bit [31:0] m_ob_sz [3];
  bit [63:0] m_ib_sz [3];
  bit [63:0] m_ib_la [3];
  bit [31:0] m_sts;
  bit [31:0] m_rdata;

  function automatic bit [31:0] m_read(input bit [7:0] a);
    case (a)
      8'h68: return m_ob_la[0][31:0];
      8'h6C: return m_ob_la[0][63:32];
      8'h70: return m_ob_sz[0];
      8'h74: return m_ob_pa[0][31:0];
      8'h78: return m_ob_pa[0][63:32];
      8'h7C: return m_ob_la[1][31:0];
      8'h80: return m_ob_la[1][63:32];
      8'h84: return m_ob_sz[1];
      8'h88: return m_ob_pa[1][31:0];
      8'h8C: return m_ob_pa[1][63:32];
      8'h90: return m_ob_sz[2];
      8'h98: return m_ib_sz[0][31:0];
      8'h9C: return m_ib_la[0][31:0];
      8'hA0: return m_ib_la[0][63:32];
      8'hA4: return m_ib_sz[1][31:0];
      8'hA8: return m_ib_la[1][31:0];
      8'hAC: return m_ib_la[1][63:32];
      8'hB0: return m_ib_sz[2][31:0];
      8'hB4: return m_ib_la[2][31:0];
      8'hB8: return m_ib_la[2][63:32];
      8'hE0: return m_sts;
      8'hF8: return m_ib_sz[0][63:32];
      8'hFC: return m_ib_sz[2][63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_write(input bit [7:0] a, input bit [31:0] d);
    case (a)
      8'h68: m_ob_la[0][31:0]  = d;
      8'h6C: m_ob_la[0][63:32] = d;
      8'h70: m_ob_sz[0]        = d;
      8'h74: m_ob_pa[0][31:0]  = d;
      8'h78: m_ob_pa[0][63:32] = d;
      8'h7C: m_ob_la[1][31:0]  = d;
      8'h80: m_ob_la[1][63:32] = d;
      8'h84: m_ob_sz[1]        = d;
      8'h88: m_ob_pa[1][31:0]  = d;
      8'h8C: m_ob_pa[1][63:32] = d;
      8'h90: m_ob_sz[2]        = d;
      8'h98: m_ib_sz[0][31:0]  = d;
      8'h9C: m_ib_la[0][31:0]  = d;
      8'hA0: m_ib_la[0][63:32] = d;
      8'hA4: m_ib_sz[1]        = {32'h0, d};
      8'hA8: m_ib_la[1][31:0]  = d;
      8'hAC: m_ib_la[1][63:32] = d;
      8'hB0: m_ib_sz[2][31:0]  = d;
      8'hB4: m_ib_la[2][31:0]  = d;
      8'hB8: m_ib_la[2][63:32] = d;
      8'hE0: m_sts             = d;
      8'hF8: m_ib_sz[0][63:32] = d;
      8'hFC: m_ib_sz[2][63:32] = d;
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_ob_sz[i] = 0;
        m_ib_sz[i] = 64'hFFFF_FFFF_0000_0000;
        m_ib_la[i] = 0;
      end
      for (int i = 0; i < 2; i++) begin
        m_ob_la[i] = 0;
        m_ob_pa[i] = 0;
      end
      m_sts   = 0;
      m_rdata = 0;
    end else if (reg_valid) begin
      if (reg_write) m_write(reg_addr, reg_wdata);
      else           m_rdata = m_read(reg_addr);
    end
  end

  // outbound: windows 0 and 1 translate, first match wins
  task automatic exp_ob(input bit [63:0] a, output bit h, output bit [1:0] i,
                        output bit [63:0] o);
    h = 0; i = 0; o = 0;
    for (int w = 0; w < 2; w++) begin
      bit [31:0] len;
      bit [63:0] off;
      len = ~(m_ob_sz[w] & 32'hFFFF_FFFE) + 32'd1;
      if (len == 0) len = 32'hFFFF_FFFF;
      off = a - m_ob_la[w];
      if (!h && m_ob_sz[w][0] && off < {32'h0, len}) begin
        h = 1; i = 2'(w); o = m_ob_pa[w] + off;
      end
    end
  endtask

  task automatic exp_ib(input bit [63:0] a, output bit h, output bit [1:0] i,
                        output bit [63:0] o);
    h = 0; i = 0; o = a;
    for (int w = 0; w < 3; w++) begin
      bit [63:0] len;
      len = ~(m_ib_sz[w] & ~64'h7) + 64'd1;
      if (!h && m_ib_sz[w][0] && a < len) begin
        h = 1; i = 2'(w); o = m_ib_la[w] + a;
      end
    end
  endtask

  // ---------------- checking ----------------
  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, got, exp);
    end
  endtask

  task automatic cmp_all();
    bit h; bit [1:0] i; bit [63:0] o;
    if (!started) return;
    chk("R13", "rdata model", 64'(reg_rdata), 64'(m_rdata));
    exp_ob(ob_addr_in, h, i, o);
    chk("R4", "ob_hit model",  64'(ob_hit), 64'(h));
    chk("R4", "ob_idx model",  64'(ob_win_idx), 64'(i));
    chk("R4", "ob_out model",  ob_addr_out, o);
    exp_ib(ib_addr_in, h, i, o);
    chk("R6", "ib_hit model",  64'(ib_hit), 64'(h));
    chk("R6", "ib_idx model",  64'(ib_win_idx), 64'(i));
    chk("R6", "ib_out model",  ib_addr_out, o);
  endtask

  task automatic tick();
    @(negedge clk);
    cmp_all();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic rd_expect(input string req, input logic [7:0] a,
                           input logic [31:0] exp);
    reg_valid = 1; reg_write = 0; reg_addr = a;
    tick();
    reg_valid = 0;
    chk(req, $sformatf("read 0x%0h", a), 64'(reg_rdata), 64'(exp));
  endtask

  task automatic look_ob(input string req, input logic [63:0] a,
                         input logic h, input logic [1:0] i, input logic [63:0] o);
    ob_addr_in = a;
    tick();
    chk(req, "ob_hit", 64'(ob_hit), 64'(h));
    if (h) begin
      chk(req, "ob_idx", 64'(ob_win_idx), 64'(i));
      chk(req, "ob_out", ob_addr_out, o);
    end
  endtask

  task automatic look_ib(input string req, input logic [63:0] a,
                         input logic h, input logic [1:0] i, input logic [63:0] o);
    ib_addr_in = a;
    tick();
    chk(req, "ib_hit", 64'(ib_hit), 64'(h));
    chk(req, "ib_idx", 64'(ib_win_idx), 64'(i));
    chk(req, "ib_out", ib_addr_out, o);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R13 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    rst_n = 0; reg_valid = 0; reg_write = 0; reg_addr = 0; reg_wdata = 0;
    ob_addr_in = 0; ib_addr_in = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    started = 1;

    // R1 reset state
    rd_expect("R1", 8'h70, 32'h0);
    rd_expect("R1", 8'hF8, 32'hFFFF_FFFF);
    rd_expect("R1", 8'h98, 32'h0);
    look_ob("R1", 64'h0, 0, 0, 0);
    look_ib("R7", 64'h1234, 0, 0, 64'h1234);

    // R9 halves
    wr(8'h68, 32'h8000_0000);
    wr(8'h6C, 32'h0000_0001);
    rd_expect("R9", 8'h68, 32'h8000_0000);
    rd_expect("R9", 8'h6C, 32'h0000_0001);

    // R4 outbound window 0: 1 MiB at 0x1_8000_0000 -> 0xC000_0000
    wr(8'h74, 32'hC000_0000);
    wr(8'h78, 32'h0);
    wr(8'h70, 32'hFFF0_0001);
    look_ob("R4", 64'h1_8001_2345, 1, 0, 64'hC001_2345);
    look_ob("R4", 64'h1_800F_FFFF, 1, 0, 64'hC00F_FFFF);
    look_ob("R4", 64'h1_8010_0000, 0, 0, 0);
    look_ob("R4", 64'h1_7FFF_FFFF, 0, 0, 0);

    // R2 disable
    wr(8'h70, 32'hFFF0_0000);
    look_ob("R2", 64'h1_8001_2345, 0, 0, 0);

    // R3 zero length widens to 0xFFFFFFFF
    wr(8'h7C, 32'h0);
    wr(8'h80, 32'h2);
    wr(8'h88, 32'h0);
    wr(8'h8C, 32'h10);
    wr(8'h84, 32'h0000_0001);
    look_ob("R3", 64'h2_FFFF_FFFE, 1, 1, 64'h10_FFFF_FFFE);
    look_ob("R3", 64'h2_FFFF_FFFF, 0, 0, 0);

    // R8 outbound priority
    wr(8'h68, 32'h0);
    wr(8'h6C, 32'h2);
    wr(8'h70, 32'hFFFF_0001);
    look_ob("R8", 64'h2_0000_0100, 1, 0, 64'hC000_0100);
    look_ob("R8", 64'h2_0001_0000, 1, 1, 64'h10_0001_0000);

    // R5 size-only window
    wr(8'h90, 32'hFFF0_0001);
    rd_expect("R5", 8'h90, 32'hFFF0_0001);
    look_ob("R5", 64'h10, 0, 0, 0);

    // R6 inbound window 0
    wr(8'h98, 32'hFFF0_0001);
    wr(8'h9C, 32'h0);
    wr(8'hA0, 32'h3);
    look_ib("R6", 64'h1234, 1, 0, 64'h3_0000_1234);
    look_ib("R7", 64'h10_0000, 0, 0, 64'h10_0000);

    // R10 window 1 size zero-extends
    wr(8'hA4, 32'hFFFF_0001);
    wr(8'hA8, 32'h0);
    wr(8'hAC, 32'h5);
    rd_expect("R10", 8'hA4, 32'hFFFF_0001);
    look_ib("R10", 64'h4_0000_0000, 1, 1, 64'h9_0000_0000);
    look_ib("R8", 64'h10, 1, 0, 64'h3_0000_0010);
    rd_expect("R9", 8'hF8, 32'hFFFF_FFFF);

    // R11 status
    wr(8'hE0, 32'hA5A5_1234);
    rd_expect("R11", 8'hE0, 32'hA5A5_1234);

    // R12 unmapped offsets
    wr(8'h94, 32'hDEAD_BEEF);
    wr(8'h00, 32'h1234_5678);
    rd_expect("R12", 8'h94, 32'h0);
    rd_expect("R12", 8'h00, 32'h0);
    rd_expect("R12", 8'hE0, 32'hA5A5_1234);
    rd_expect("R12", 8'h90, 32'hFFF0_0001);
    look_ob("R12", 64'h2_0000_0100, 1, 0, 64'hC000_0100);

    // R13 hold between reads
    held = reg_rdata;
    wr(8'hE0, 32'h0);
    tick();
    chk("R13", "rdata held", 64'(reg_rdata), 64'(held));

    // mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      logic [63:0] bases [4];
      bases[0] = 64'h1_8000_0000; bases[1] = 64'h2_0000_0000;
      bases[2] = 64'h2_FFFF_FFF0; bases[3] = 64'h0;
      ob_addr_in = bases[$urandom_range(3)] + 64'($urandom_range(32'h2_0000));
      ib_addr_in = ($urandom_range(1) == 1) ? 64'($urandom_range(32'h12_0000))
                                            : {32'($urandom_range(8)), $urandom()};
      if (n % 37 == 5) wr(8'h70, {$urandom_range(32'hFFFF) , 16'h0001} | 32'hFFF0_0000);
      else if (n % 41 == 7) wr(8'hB0, {16'hFFFF, 16'($urandom()) | 16'h1});
      else tick();
    end

    done = 1;
    summary();
    $finish;
  end

endmodule